// File: doc/BRIEF.md
# Addressable LED Strip Frame Transmitter

This block is a serial master for a chain of two-wire addressable RGB pixels. A pulse on `start` begins one refresh of the whole chain. The block first shifts out an all-zero header word. It then pulls one pixel at a time over a valid/ready handshake and sends each as a 32-bit word. It ends with a run of padding bits whose only job is to supply the extra clock edges that push the final pixel's data down the chain. The generated clock and data lines are plain outputs. `busy` covers the whole frame, and `done` marks its end.

The serial clock runs at the system clock divided by `2*CLK_DIV`. Its high and low phases have equal length, and it idles low. Data changes only when the generated clock falls, so the pixel sees a stable level on every rising edge. If no pixel is offered when the next word is due, the clock stops low until one arrives. The chain therefore never receives filler data.

The sequencer states and transitions are:
- IDLE -> HEAD when `start` is high.
- HEAD -> WAIT at the end of the word, when pixels remain.
- WAIT -> PIXEL on the handshake.
- PIXEL -> WAIT at the end of the word, when pixels remain.
- PIXEL -> TAIL at the end of the last pixel word.
- TAIL -> IDLE after the last padding bit, with `done` raised.

Top module: `ledchain_tx`

## Requirements
- R1: While reset is held, `led_clk`, `busy`, `done` and `pix_ready` are all 0.
- R2: A high `start` in IDLE begins a frame on the next clock. A `start` seen while `busy` is high has no effect, so the frame in progress keeps its length and content. A `start` held high during the `done` cycle begins the next frame on the following clock.
- R3: The first 32 bits of every frame are 0.
- R4: Each pixel word is sent MSB first and has these fields:
  - bits 31:29 are `111`;
  - bits 28:24 are `pix_bright`;
  - bits 23:0 are `pix_rgb`, with red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: After the last pixel come exactly TAIL bits, all equal to 1, where TAIL is ceil(NUM_PIX/2) rounded up to a multiple of 8. A frame therefore holds 32 + 32*NUM_PIX + TAIL bits.
- R6: `led_dat` is unchanged in every system cycle in which `led_clk` is high. It only changes while the clock is low.
- R7: Every high phase of `led_clk` lasts exactly CLK_DIV system cycles. Every low phase inside a frame lasts at least CLK_DIV cycles.
- R8: `pix_ready` rises only after the previous word has been fully shifted out: after 32 + 32*k bits for pixel k, counting from 0. While `pix_ready` is high, `led_clk` stays low, which stalls the chain until `pix_valid` arrives.
- R9: `done` is high for exactly one cycle after the final padding bit. `busy` falls in that same cycle, and `led_clk` is low whenever `busy` is low.
- R10: Exactly NUM_PIX pixels are accepted per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one frame |
| pix_valid | input | 1 | Pixel data offered |
| pix_ready | output | 1 | Block will take a pixel this cycle |
| pix_bright | input | 5 | Global brightness of the offered pixel (0..31) |
| pix_rgb | input | 24 | Colour of the offered pixel: red, green, blue from the top |
| led_clk | output | 1 | Generated serial clock, idles low |
| led_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two things can land in the same cycle: the end-of-frame `done` pulse and the acceptance of a new `start`. The bench holds `start` high across the end of a frame. It then checks three things: `busy` is low only for the `done` cycle and is high on the next one, the new frame's bit stream is complete, and the earlier frame's count is unaffected. A second coincidence is the word end and the next pixel handshake. With `pix_valid` already high, the bench checks that the handshake lands after exactly 32 + 32*k bits and that the clock never runs while `pix_ready` is high.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;

    localparam int WORD_BITS = 32;
    localparam int HDR_BITS  = 3;
    localparam logic [HDR_BITS-1:0] PIX_HDR = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HEAD  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_PIXEL = 3'd3,
        ST_TAIL  = 3'd4
    } seq_state_t;

    function automatic int pad_bits(input int npix);
        return (((npix + 1) / 2 + 7) / 8) * 8;
    endfunction

endpackage

// File: rtl/ledchain_clkdiv.sv
module ledchain_clkdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (HALF < 2) ? 1 : $clog2(HALF);

    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == CNT_W'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ledchain_shifter.sv
module ledchain_shifter #(
    parameter int  W    = 32,
    parameter logic FILL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         sdo
);
    logic [W-1:0] sreg_q;

    assign sdo = sreg_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= load_word;
        end else if (shift) begin
            sreg_q <= {sreg_q[W-2:0], FILL};
        end
    end
endmodule

// File: rtl/ledchain_seq.sv
module ledchain_seq
    import ledchain_pkg::*;
#(
    parameter int NUM_PIX   = 64,
    parameter int TAIL_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pix_valid,
    input  logic tick,
    output logic pix_ready,
    output logic ld_head,
    output logic ld_pix,
    output logic ld_tail,
    output logic shift_en,
    output logic div_en,
    output logic led_ck,
    output logic busy,
    output logic done
);
    localparam int MAXB = (TAIL_BITS > WORD_BITS) ? TAIL_BITS : WORD_BITS;
    localparam int CW   = $clog2(MAXB + 1);
    localparam int PW   = $clog2(NUM_PIX + 1);

    seq_state_t     st_q, st_d;
    logic [CW-1:0]  bits_q;
    logic [PW-1:0]  pix_q;
    logic           ck_q;
    logic           done_q;
    logic           shifting;
    logic           rise;
    logic           fall;
    logic           word_end;
    logic           last_pix;

    assign shifting = (st_q == ST_HEAD) || (st_q == ST_PIXEL) || (st_q == ST_TAIL);
    assign rise     = shifting && tick && !ck_q;
    assign fall     = shifting && tick && ck_q;
    assign word_end = fall && (bits_q == CW'(1));
    assign last_pix = (pix_q == PW'(NUM_PIX));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_HEAD;
            ST_HEAD,
            ST_PIXEL: if (word_end) st_d = last_pix ? ST_TAIL : ST_WAIT;
            ST_WAIT:  if (pix_valid) st_d = ST_PIXEL;
            ST_TAIL:  if (word_end) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // bit / pixel counters, serial clock phase, end pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            pix_q  <= '0;
            ck_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st_q == ST_TAIL) && word_end;
            if (rise) begin
                ck_q <= 1'b1;
            end else if (fall) begin
                ck_q <= 1'b0;
            end
            if (st_q == ST_IDLE && start) begin
                bits_q <= CW'(WORD_BITS);
                pix_q  <= '0;
            end else if (st_q == ST_WAIT && pix_valid) begin
                bits_q <= CW'(WORD_BITS);
                pix_q  <= pix_q + 1'b1;
            end else if (word_end && st_q != ST_TAIL && last_pix) begin
                bits_q <= CW'(TAIL_BITS);
            end else if (fall) begin
                bits_q <= bits_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pix_ready = (st_q == ST_WAIT);
        ld_head   = (st_q == ST_IDLE) && start;
        ld_pix    = (st_q == ST_WAIT) && pix_valid;
        ld_tail   = word_end && (st_q != ST_TAIL) && last_pix;
        shift_en  = fall && (bits_q != CW'(1));
        div_en    = shifting;
        led_ck    = ck_q;
        busy      = (st_q != ST_IDLE);
        done      = done_q;
    end
endmodule

// File: rtl/ledchain_tx.sv
module ledchain_tx
    import ledchain_pkg::*;
#(
    parameter int NUM_PIX = 64,
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        pix_valid,
    output logic        pix_ready,
    input  logic [4:0]  pix_bright,
    input  logic [23:0] pix_rgb,
    output logic        led_clk,
    output logic        led_dat,
    output logic        busy,
    output logic        done
);
    localparam int TAIL_BITS = pad_bits(NUM_PIX);

    logic                 tick;
    logic                 ld_head, ld_pix, ld_tail;
    logic                 shift_en, div_en;
    logic                 sdo;
    logic [WORD_BITS-1:0] load_word;

    always_comb begin
        if (ld_pix) begin
            load_word = {PIX_HDR, pix_bright, pix_rgb};
        end else if (ld_tail) begin
            load_word = '1;
        end else begin
            load_word = '0;
        end
    end

    ledchain_clkdiv #(.HALF(CLK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .tick  (tick)
    );

    ledchain_shifter #(.W(WORD_BITS), .FILL(1'b1)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_head | ld_pix | ld_tail),
        .load_word (load_word),
        .shift     (shift_en),
        .sdo       (sdo)
    );

    ledchain_seq #(.NUM_PIX(NUM_PIX), .TAIL_BITS(TAIL_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pix_valid (pix_valid),
        .tick      (tick),
        .pix_ready (pix_ready),
        .ld_head   (ld_head),
        .ld_pix    (ld_pix),
        .ld_tail   (ld_tail),
        .shift_en  (shift_en),
        .div_en    (div_en),
        .led_ck    (led_clk),
        .busy      (busy),
        .done      (done)
    );

    assign led_dat = sdo & div_en;
endmodule

// File: rtl/ledchain_tx_chk.sv
module ledchain_tx_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic pix_valid,
    input logic pix_ready,
    input logic led_clk,
    input logic led_dat,
    input logic busy,
    input logic done
);
    logic [15:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (led_clk) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end else begin
            hi_cnt_q <= '0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!led_clk && !pix_ready)); // R9
    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        led_clk |-> $stable(led_dat)); // R6
    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> !led_clk); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |=> !led_clk); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R9
    AST_HI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_clk) |-> (hi_cnt_q == 16'(CLK_DIV))); // R7
endmodule

bind ledchain_tx ledchain_tx_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .led_clk   (led_clk),
    .led_dat   (led_dat),
    .busy      (busy),
    .done      (done)
);

// File: tb/ledchain_tx_tb.sv
module ledchain_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 5;
    localparam int DIV   = 2;
    localparam int TAIL  = (((N + 1) / 2 + 7) / 8) * 8;
    localparam int TOTAL = 32 + 32 * N + TAIL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pix_valid = 1'b0;
    logic        pix_ready;
    logic [4:0]  pix_bright = '0;
    logic [23:0] pix_rgb = '0;
    logic        led_clk, led_dat, busy, done;

    int checks = 0;
    int failures = 0;
    int rx_n = 0;
    logic rx_bits [0:4095];
    int width_err = 0;
    int hold_err = 0;
    int hi_run = 0;
    int lo_run = 0;
    logic prev_dat = 1'b0;
    logic [4:0]  pb   [0:N-1];
    logic [23:0] prgb [0:N-1];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ledchain_tx #(.NUM_PIX(N), .CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_bright(pix_bright), .pix_rgb(pix_rgb),
        .led_clk(led_clk), .led_dat(led_dat), .busy(busy), .done(done)
    );

    // receiver model: capture on each rising serial clock
    always @(posedge led_clk) begin
        rx_bits[rx_n % 4096] = led_dat;
        rx_n = rx_n + 1;
    end

    // phase width and data hold monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (led_clk && led_dat !== prev_dat) hold_err++;
            if (led_clk) begin
                if (lo_run != 0 && lo_run < DIV) width_err++;
                lo_run = 0;
                hi_run++;
            end else begin
                if (hi_run != 0 && hi_run != DIV) width_err++;
                hi_run = 0;
                if (busy) lo_run++;
            end
            prev_dat = led_dat;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int i);
        logic [31:0] w;
        if (i < 32) return 1'b0;
        if (i < 32 + 32 * N) begin
            w = {3'b111, pb[(i - 32) / 32], prgb[(i - 32) / 32]};
            return w[31 - ((i - 32) % 32)];
        end
        return 1'b1;
    endfunction

    task automatic compare_region(input int base, input int lo, input int hi,
                                  input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int i = lo; i < hi; i++) begin
            if (rx_bits[(base + i) % 4096] !== exp_bit(i)) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, {what, " bit mismatch at index"}, first, -1);
    endtask

    // mode: 0 directed, 1 random, 2 start pulsed mid-frame,
    //       3 start held through done, 4 continuation of a held start
    task automatic run_frame(input int mode, input int gap_max);
        int base = rx_n;
        int hs = 0;
        int w0 = width_err;
        int h0 = hold_err;
        int gap;
        if (mode != 0) begin
            for (int k = 0; k < N; k++) begin
                pb[k]   = 5'($urandom);
                prgb[k] = 24'($urandom);
            end
        end
        if (mode == 4) begin
            @(negedge clk);
            chk(busy === 1'b1, "R2", "held start begins next frame busy", busy, 1);
            start = 1'b0;
        end else begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            if (mode != 3) start = 1'b0;
        end
        for (int k = 0; k < N; k++) begin
            gap = (gap_max == 0) ? 0 : int'($urandom_range(0, gap_max));
            if (mode == 2 && k == 2) begin
                @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            repeat (gap) @(negedge clk);
            pix_valid  = 1'b1;
            pix_bright = pb[k];
            pix_rgb    = prgb[k];
            do @(negedge clk); while (!pix_ready);
            chk(rx_n - base == 32 + 32 * k, "R8", "bits before pixel handshake",
                rx_n - base, 32 + 32 * k);
            hs++;
            @(negedge clk);
            pix_valid = 1'b0;
            pix_rgb   = 24'($urandom);
            chk(pix_ready === 1'b0, "R8", "ready drops after word taken", pix_ready, 0);
        end
        do @(negedge clk); while (!done);
        chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
        chk(led_clk === 1'b0, "R9", "clock low at done", led_clk, 0);
        chk(rx_n - base == TOTAL, (mode == 2) ? "R2" : "R5", "frame bit count",
            rx_n - base, TOTAL);
        chk(hs == N, "R10", "pixels accepted", hs, N);
        compare_region(base, 0, 32, "R3", "header word");
        compare_region(base, 32, 32 + 32 * N, "R4", "pixel words");
        compare_region(base, 32 + 32 * N, TOTAL, "R5", "padding bits");
        chk(width_err == w0, "R7", "clock phase width errors", width_err - w0, 0);
        chk(hold_err == h0, "R6", "data change while clock high", hold_err - h0, 0);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done lasts one cycle", done, 0);
        if (mode != 3) chk(busy === 1'b0, "R2", "idle after frame", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(led_clk === 1'b0, "R1", "reset led_clk", led_clk, 0);
        chk(busy === 1'b0, "R1", "reset busy", busy, 0);
        chk(done === 1'b0, "R1", "reset done", done, 0);
        chk(pix_ready === 1'b0, "R1", "reset pix_ready", pix_ready, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed: brightest white, all-zero pixel, alternating patterns
        pb[0] = 5'd31; prgb[0] = 24'hFFFFFF;
        pb[1] = 5'd0;  prgb[1] = 24'h000000;
        pb[2] = 5'd21; prgb[2] = 24'hAA55AA;
        pb[3] = 5'd10; prgb[3] = 24'h55AA55;
        pb[4] = 5'd1;  prgb[4] = 24'h800001;
        run_frame(0, 0);
        run_frame(1, 40);
        run_frame(1, 3);
        run_frame(2, 10);
        run_frame(3, 0);
        run_frame(4, 5);
        run_frame(1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule